// File: doc/BRIEF.md
# Serial Conversion Result Transmitter

This block sends one 16-bit conversion result over a three-wire serial link that it clocks itself. A one-cycle start pulse loads the result. The block then drives an active-low frame strobe, a serial clock and a data line. All three are timed from the master clock that runs the block. The receiver samples the data line on each rising serial clock edge, most significant bit first.

Before the word is loaded, the block can replace it with a full-scale code when an out-of-range flag is raised. It can also change the output coding from straight binary to two's complement. A busy flag stays high for the whole frame. Start pulses that arrive during that time are dropped.

Top module: `serial_result_port`

## Requirements
- R1: While reset is active, and whenever no frame is in progress, `sclk_o` is high, `frame_n_o` is high, `sdata_o` is low and `busy_o` is low.
- R2: A start pulse that is sampled while the block is idle begins a frame. On that same clock edge `frame_n_o` goes low and `sclk_o` goes low. The first rising edge of `sclk_o` follows HALF_CYC master clocks later (2 by default).
- R3: Every low phase and every high phase of `sclk_o` inside a frame lasts exactly HALF_CYC master clocks. A frame contains exactly WORD_W rising edges (16 by default), so it spans 2·HALF_CYC·WORD_W master clocks (64 by default).
- R4: `sdata_o` changes only together with a falling edge of `sclk_o`, or at the start or end of a frame. It therefore stays stable across every rising edge.
- R5: The word is captured on the clock edge that accepts the start pulse. It is sent most significant bit first.
- R6: `frame_n_o` returns high HALF_CYC master clocks after the last rising edge of `sclk_o`. On that edge `sdata_o` returns low and `sclk_o` stays high.
- R7: With `twos_i` = 0 the word is sent in straight binary. With `twos_i` = 1, bit 15 (the MSB) of the word, taken after any clamping, is inverted to give two's complement.
- R8: When `over_i` = 1 the word becomes all ones before coding. When `under_i` = 1 and `over_i` = 0 it becomes all zeros. `over_i` wins when both flags are set.
- R9: `busy_o` is high exactly while `frame_n_o` is low. A start pulse that arrives while `busy_o` is high changes neither the frame in progress nor the word it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to send `result_i` |
| result_i | input | 16 | Raw conversion result |
| over_i | input | 1 | Result is above full scale |
| under_i | input | 1 | Result is below full scale |
| twos_i | input | 1 | 0 = straight binary, 1 = two's complement |
| sclk_o | output | 1 | Serial clock out, idle high |
| sdata_o | output | 1 | Serial data out, idle low |
| frame_n_o | output | 1 | Active-low frame strobe |
| busy_o | output | 1 | Frame in progress |

## Verification
The bound checker watches the timing of the link on every cycle:
- the idle levels of the lines;
- that `busy_o` agrees with the frame strobe;
- that the serial clock phases have a fixed length;
- that the data line moves only on falling serial clock edges;
- that the strobe brackets the clock correctly at both ends.

The directed scenarios cover what depends on the value being sent. They check that the recovered word is correct and arrives MSB first, the clamp codes and their priority, the MSB inversion for two's complement, and that a start pulse arriving in mid-frame is dropped.

// File: rtl/serial_result_pkg.sv
package serial_result_pkg;

    // Output coding selected by the coding input.
    typedef enum logic {
        CODE_STRAIGHT = 1'b0,
        CODE_TWOS     = 1'b1
    } code_sel_e;

endpackage

// File: rtl/word_former.sv
// Clamps the raw result on an out-of-range flag (over wins), then applies the coding.
module word_former
    import serial_result_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] raw_i,
    input  logic              over_i,
    input  logic              under_i,
    input  code_sel_e         code_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] clamped;

    always_comb begin
        if (over_i)       clamped = '1;
        else if (under_i) clamped = '0;
        else              clamped = raw_i;

        word_o = clamped;
        if (code_i == CODE_TWOS) word_o[WORD_W-1] = ~clamped[WORD_W-1];
    end
endmodule

// File: rtl/phase_timer.sv
// Pulses tick_o on the last master clock of each serial clock phase while run_i is high.
module phase_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CW'(HALF_CYC - 1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import serial_result_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] result_i,
    input  logic              over_i,
    input  logic              under_i,
    input  logic              twos_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              frame_n_o,
    output logic              busy_o
);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              frame_n;
        logic [WORD_W-1:0] shreg;
        logic [BW-1:0]     bits_left;
    } port_state_t;

    port_state_t       st_d, st_q;
    logic [WORD_W-1:0] formed;
    logic              tick;

    word_former #(.WORD_W(WORD_W)) u_former (
        .raw_i   (result_i),
        .over_i  (over_i),
        .under_i (under_i),
        .code_i  (code_sel_e'(twos_i)),
        .word_o  (formed)
    );

    phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.active),
        .tick_o (tick)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            // Idle: a start pulse opens the frame with the first low phase.
            if (start_i) begin
                st_d.active    = 1'b1;
                st_d.frame_n   = 1'b0;
                st_d.sclk      = 1'b0;
                st_d.shreg     = formed;
                st_d.bits_left = BW'(WORD_W - 1);
            end
        end else if (tick) begin
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;                 // sampling edge
            end else if (st_q.bits_left == '0) begin
                st_d.active  = 1'b0;              // trailing high phase done
                st_d.frame_n = 1'b1;
            end else begin
                st_d.sclk      = 1'b0;            // next bit on falling edge
                st_d.shreg     = {st_q.shreg[WORD_W-2:0], 1'b0};
                st_d.bits_left = st_q.bits_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active    <= 1'b0;
            st_q.sclk      <= 1'b1;
            st_q.frame_n   <= 1'b1;
            st_q.shreg     <= '0;
            st_q.bits_left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o    = st_q.sclk;
    assign frame_n_o = st_q.frame_n;
    assign busy_o    = st_q.active;
    assign sdata_o   = st_q.active & st_q.shreg[WORD_W-1];
endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk #(
    parameter int HALF_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sclk_o,
    input logic sdata_o,
    input logic frame_n_o,
    input logic busy_o
);
    logic       sclk_prev_q;
    logic [7:0] run_q;

    // Counts master clocks since the last serial clock transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            run_q       <= '0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (sclk_o != sclk_prev_q) run_q <= '0;
            else if (run_q != 8'hFF)   run_q <= run_q + 1'b1;
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && frame_n_o && !sdata_o));

    assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n_o) |-> $fell(sclk_o));

    assert_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (sclk_o != sclk_prev_q)) |-> (run_q == 8'(HALF_CYC - 1)));

    assert_data_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$stable(sdata_o)) |-> $fell(sclk_o));

    assert_frame_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n_o) |-> (sclk_o && $past(sclk_o)));

    assert_busy_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !frame_n_o);
endmodule

bind serial_result_port serial_result_port_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_o    (sclk_o),
    .sdata_o   (sdata_o),
    .frame_n_o (frame_n_o),
    .busy_o    (busy_o)
);

// File: tb/tb_serial_result_port.sv
`timescale 1ns/1ps
module tb_serial_result_port;
    localparam int FRAME = 64;   // 2 * HALF_CYC(2) * 16 bits

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [15:0] result = '0;
    logic over = 1'b0, under = 1'b0, twos = 1'b0;
    logic sclk, sdata, frame_n, busy;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_result_port dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .result_i(result),
        .over_i(over), .under_i(under), .twos_i(twos),
        .sclk_o(sclk), .sdata_o(sdata), .frame_n_o(frame_n), .busy_o(busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1: idle levels.
    task automatic check_idle(input string what);
        check("R1", what, {sclk, frame_n, sdata, busy}, 4'b1100);
    endtask

    // Sends one word and checks it. The returned frame must carry exp_word.
    // inj_k >= 0 pulses a second start (with other data) at that offset in the frame.
    task automatic send(input logic [15:0] raw, input logic ov, input logic un,
                        input logic tw, input logic [15:0] exp_word,
                        input int inj_k, input string tag);
        logic [15:0] rx = '0;
        int e_clk = 0, e_dat = 0, e_bsy = 0;
        @(negedge clk);
        start = 1'b1; result = raw; over = ov; under = un; twos = tw;
        @(negedge clk);
        start = 1'b0; result = ~raw;
        for (int k = 0; k < FRAME; k++) begin
            // R2 R3: sclk low for k%4 in {0,1}, high for k%4 in {2,3}
            if (sclk !== ((k >> 1) & 1)) e_clk++;
            // R4 R5: bit 15-k/4 is held for the whole 4-clock bit slot
            if (sdata !== exp_word[15 - (k >> 2)]) e_dat++;
            // R9: strobe low and busy high through the frame
            if (frame_n !== 1'b0 || busy !== 1'b1) e_bsy++;
            if ((k % 4) == 2) rx = {rx[14:0], sdata};
            if (inj_k >= 0 && k == inj_k) begin
                start = 1'b1; result = 16'hFFFF; over = 1'b1; twos = ~tw;
            end
            if (inj_k >= 0 && k == inj_k + 1) start = 1'b0;
            @(negedge clk);
        end
        check("R3", {tag, " sclk phase errors"}, e_clk, 0);
        check("R4", {tag, " sdata slot errors"}, e_dat, 0);
        check("R9", {tag, " busy/strobe errors"}, e_bsy, 0);
        check("R5", {tag, " received word"}, rx, exp_word);
        check("R6", {tag, " end of frame lines"}, {sclk, frame_n, sdata, busy}, 4'b1100);
        over = 1'b0; under = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        send(16'hA5C3, 0, 0, 0, 16'hA5C3, -1, "R7 binary");
        send(16'h1234, 0, 0, 1, 16'h9234, -1, "R7 twos");
        send(16'hF00D, 0, 0, 1, 16'h700D, -1, "R7 twos msb set");
        send(16'h0123, 1, 0, 0, 16'hFFFF, -1, "R8 over binary");
        send(16'h0123, 1, 0, 1, 16'h7FFF, -1, "R8 over twos");
        send(16'hFEDC, 0, 1, 0, 16'h0000, -1, "R8 under binary");
        send(16'hFEDC, 0, 1, 1, 16'h8000, -1, "R8 under twos");
        send(16'h5555, 1, 1, 0, 16'hFFFF, -1, "R8 both flags");
        send(16'h0F0F, 0, 0, 0, 16'h0F0F, 20, "R9 mid-frame start");
        send(16'h8001, 0, 0, 0, 16'h8001, 62, "R9 late start");
        // After the frame the late start must not have opened a new frame.
        @(negedge clk);
        check_idle("R9 no frame from ignored start");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule